// File: doc/BRIEF.md
# Move-Instruction Decoder with One-Shot Prefix

This block decodes a fixed 16-bit instruction word in which every operation is a transfer from a source to a destination. Higher-level operations are not encoded as opcodes. They come from the side effects of reading or writing particular register addresses, and those side effects belong to the register files and peripherals downstream. The decoder separates the word into a source-format flag, an 8-bit source field and a 7-bit destination field. It resolves the source to either an immediate value or a module/index register address, and it resolves the destination to a module and an extended index.

A one-shot prefix register, selected as destination module 0xB with an immediate source, holds 8 bits for exactly one following instruction. Those bits become the upper byte of an immediate and the upper part of the destination index. A prefix load uses one input beat, the extra cycle it costs, and produces no output item.

Both the instruction input and the decoded output are valid/ready streams. An input word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A decoded item shows on the outputs in the cycle after its word is accepted. While `out_valid` is high and `out_ready` is low, the item and `out_valid` stay frozen and no new word is taken.

Top module: `move_decoder`

## Requirements
- R1: After reset `out_valid` and `dst_wr` are 0, `in_ready` is 1, and the held prefix is zero.
- R2: A word with bit 15 = 0 has an immediate source. `out_src_imm`=1, `out_imm` = {held prefix, word[7:0]}, and `out_src_module` and `out_src_index` are 0.
- R3: A word with bit 15 = 1 has a register source. `out_src_imm`=0, `out_src_module`=word[3:0], `out_src_index`=word[7:4], and `out_imm`=0.
- R4: For any output item, `out_dst_module`=word[11:8] and `out_dst_index` = {held prefix[4:0], word[14:12]}. Prefix bits 7:5 do not reach the index.
- R5: A word with bit 15 = 0 and word[11:8] = 0xB loads word[7:0] into the prefix and produces no output item.
- R6: The prefix is cleared to zero once any word that produces an output item has been accepted, so it applies to exactly one instruction.
- R7: A prefix load that follows another prefix load replaces the held value. It does not apply or clear the older value first.
- R8: A register-source word (bit 15 = 1) addressed to module 0xB is an ordinary move. It produces an output item, leaves the prefix unloaded, and consumes and clears any held prefix.
- R9: While `out_valid`=1 and `out_ready`=0, all output fields and `out_valid` hold their values and `in_ready` is 0.
- R10: `dst_wr` is high for exactly one cycle per output item, namely the cycle in which that item is taken (`out_valid` and `out_ready` both high). Items leave in the order their words were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is presented |
| in_ready | output | 1 | Decoder can accept a word this cycle |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded item is present (decode valid) |
| out_ready | input | 1 | Consumer takes the item this cycle |
| out_src_imm | output | 1 | 1: source is immediate, 0: source is a register |
| out_src_module | output | 4 | Source module number (register source) |
| out_src_index | output | 4 | Source index within the module (register source) |
| out_imm | output | 16 | Extended immediate value (immediate source) |
| out_dst_module | output | 4 | Destination module number |
| out_dst_index | output | 8 | Extended destination index |
| dst_wr | output | 1 | Destination write strobe, one cycle per item |

## Verification
A prefix that lingers or is lost shows up directly in the next output item. It appears as a wrong upper byte in `out_imm`, or as wrong upper bits in `out_dst_index`, on the first item after the faulty load or consume. A spurious or swallowed item desynchronises the in-order stream, so every comparison after that point fails. A broken hold under back-pressure changes an output field in the first stalled cycle.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
  localparam int WORD_W     = 16;
  localparam int SRC_W      = 8;
  localparam int MOD_W      = 4;
  localparam int SIDX_W     = SRC_W - MOD_W;
  localparam int SUB_W      = 3;
  localparam int PFX_W      = 8;
  localparam int PFX_IDX_W  = 5;
  localparam int DIDX_W     = SUB_W + PFX_IDX_W;
  localparam int IMM_W      = PFX_W + SRC_W;
  localparam logic [MOD_W-1:0] PFX_MODULE = 4'hB;

  typedef struct packed {
    logic              src_imm;
    logic [MOD_W-1:0]  src_mod;
    logic [SIDX_W-1:0] src_idx;
    logic [IMM_W-1:0]  imm;
    logic [MOD_W-1:0]  dst_mod;
    logic [DIDX_W-1:0] dst_idx;
  } move_t;

  localparam int MOVE_W = $bits(move_t);
endpackage

// File: rtl/mvdec_field_split.sv
module mvdec_field_split
  import mvdec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [PFX_W-1:0]  pfx,
  output move_t             dec,
  output logic              pfx_wr
);
  localparam int FMT_BIT = WORD_W - 1;
  localparam int DMOD_LO = SRC_W;
  localparam int DSUB_LO = SRC_W + MOD_W;

  logic              is_imm;
  logic [SRC_W-1:0]  src_field;
  logic [MOD_W-1:0]  dmod;
  logic [SUB_W-1:0]  dsub;

  always_comb begin
    is_imm    = ~word[FMT_BIT];
    src_field = word[SRC_W-1:0];
    dmod      = word[DMOD_LO +: MOD_W];
    dsub      = word[DSUB_LO +: SUB_W];

    dec.src_imm = is_imm;
    dec.dst_mod = dmod;
    dec.dst_idx = {pfx[PFX_IDX_W-1:0], dsub};
    if (is_imm) begin
      dec.src_mod = '0;
      dec.src_idx = '0;
      dec.imm     = {pfx, src_field};
    end else begin
      dec.src_mod = src_field[MOD_W-1:0];
      dec.src_idx = src_field[SRC_W-1:MOD_W];
      dec.imm     = '0;
    end
    pfx_wr = is_imm && (dmod == PFX_MODULE);
  end
endmodule

// File: rtl/mvdec_prefix_reg.sv
module mvdec_prefix_reg
  import mvdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             load,
  input  logic [PFX_W-1:0] load_val,
  output logic [PFX_W-1:0] pfx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pfx <= '0;
    else if (accept)
      pfx <= load ? load_val : '0;
  end

  assert_pfx_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && load) |=> (pfx == $past(load_val)));

  assert_pfx_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load) |=> (pfx == '0));

  assert_pfx_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(pfx));
endmodule

// File: rtl/mvdec_out_stage.sv
module mvdec_out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          can_push,
  output logic          valid,
  input  logic          ready,
  output logic [DW-1:0] data
);
  assign can_push = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (can_push) begin
      valid <= push;
      if (push) data <= push_data;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  assert_push_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && can_push) |=> (valid && data == $past(push_data)));
endmodule

// File: rtl/move_decoder.sv
module move_decoder
  import mvdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_src_imm,
  output logic [MOD_W-1:0]    out_src_module,
  output logic [SIDX_W-1:0]   out_src_index,
  output logic [IMM_W-1:0]    out_imm,
  output logic [MOD_W-1:0]    out_dst_module,
  output logic [DIDX_W-1:0]   out_dst_index,
  output logic                dst_wr
);
  logic [PFX_W-1:0]  pfx;
  move_t             dec;
  move_t             held;
  logic [MOVE_W-1:0] held_bits;
  logic              pfx_wr;
  logic              in_fire;
  logic              stage_free;

  mvdec_field_split u_split (
    .word   (in_word),
    .pfx    (pfx),
    .dec    (dec),
    .pfx_wr (pfx_wr)
  );

  assign in_ready = stage_free;
  assign in_fire  = in_valid && stage_free;

  mvdec_prefix_reg u_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (in_fire),
    .load     (pfx_wr),
    .load_val (in_word[SRC_W-1:0]),
    .pfx      (pfx)
  );

  mvdec_out_stage #(.DW(MOVE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_fire && !pfx_wr),
    .push_data (dec),
    .can_push  (stage_free),
    .valid     (out_valid),
    .ready     (out_ready),
    .data      (held_bits)
  );

  assign held           = move_t'(held_bits);
  assign out_src_imm    = held.src_imm;
  assign out_src_module = held.src_mod;
  assign out_src_index  = held.src_idx;
  assign out_imm        = held.imm;
  assign out_dst_module = held.dst_mod;
  assign out_dst_index  = held.dst_idx;
  assign dst_wr         = out_valid && out_ready;

  assert_prefix_no_item_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && pfx_wr) |=> !out_valid);

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_reg_src_no_imm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_src_imm) |-> (out_imm == '0));
endmodule

// File: tb/test_move_decoder.sv
module test_move_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_src_imm;
  logic [3:0]  out_src_module;
  logic [3:0]  out_src_index;
  logic [15:0] out_imm;
  logic [3:0]  out_dst_module;
  logic [7:0]  out_dst_index;
  logic        dst_wr;

  int tests = 0;
  int fails = 0;
  int taken = 0;
  int pushed = 0;
  logic       throttle = 1'b0;
  logic [7:0] model_pfx = '0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    logic        imm_src;
    logic [3:0]  smod;
    logic [3:0]  sidx;
    logic [15:0] imm;
    logic [3:0]  dmod;
    logic [7:0]  didx;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  move_decoder i_move_decoder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src_imm(out_src_imm), .out_src_module(out_src_module),
    .out_src_index(out_src_index), .out_imm(out_imm),
    .out_dst_module(out_dst_module), .out_dst_index(out_dst_index),
    .dst_wr(dst_wr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: presents one word, waits for acceptance, updates the model
  task automatic send(input logic [15:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    forever begin
      #9;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    if (!w[15] && w[11:8] == 4'hB) begin
      model_pfx = w[7:0];
    end else begin
      e.imm_src = !w[15];
      e.smod    = w[15] ? w[3:0] : 4'h0;
      e.sidx    = w[15] ? w[7:4] : 4'h0;
      e.imm     = w[15] ? 16'h0 : {model_pfx, w[7:0]};
      e.dmod    = w[11:8];
      e.didx    = {model_pfx[4:0], w[14:12]};
      e.tag     = tag;
      sb.push_back(e);
      pushed++;
      model_pfx = '0;
    end
    #1;
    in_valid = 1'b0;
  endtask

  // consumer ready pattern
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = throttle ? (lfsr[0] & lfsr[3]) : 1'b1;
  end

  // monitor: scoreboard pop and stall hold check
  logic        prev_stall = 1'b0;
  logic [36:0] prev_out = '0;
  initial forever begin
    exp_t e;
    logic [36:0] cur;
    @(negedge clk);
    if (rst_n) begin
      cur = {out_src_imm, out_src_module, out_src_index, out_imm, out_dst_module, out_dst_index};
      if (prev_stall)
        check(out_valid && cur == prev_out, "R9", "stalled item changed", {27'b0, out_valid, cur[3:0]}, {27'b0, 1'b1, prev_out[3:0]});
      if (out_valid && !out_ready)
        check(!in_ready, "R9", "in_ready during stall", {31'b0, in_ready}, 32'h0);
      check(dst_wr == (out_valid && out_ready), "R10", "dst_wr strobe", {31'b0, dst_wr}, {31'b0, out_valid && out_ready});
      prev_stall = out_valid && !out_ready;
      prev_out   = cur;
      if (out_valid && out_ready) begin
        taken++;
        if (sb.size() == 0) begin
          check(1'b0, "R5", "unexpected item", {16'b0, out_imm}, 32'h0);
        end else begin
          e = sb.pop_front();
          check(out_src_imm == e.imm_src, e.tag, "src format (R2/R3)", {31'b0, out_src_imm}, {31'b0, e.imm_src});
          check(out_src_module == e.smod && out_src_index == e.sidx, e.tag, "src reg (R3)",
                {24'b0, out_src_index, out_src_module}, {24'b0, e.sidx, e.smod});
          check(out_imm == e.imm, e.tag, "immediate (R2)", {16'b0, out_imm}, {16'b0, e.imm});
          check(out_dst_module == e.dmod, e.tag, "dst module (R4)", {28'b0, out_dst_module}, {28'b0, e.dmod});
          check(out_dst_index == e.didx, e.tag, "dst index (R4)", {24'b0, out_dst_index}, {24'b0, e.didx});
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!out_valid, "R1", "out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready, "R1", "in_ready after reset", {31'b0, in_ready}, 32'h1);
    check(!dst_wr, "R1", "dst_wr after reset", {31'b0, dst_wr}, 32'h0);

    send(16'hD372, "R3");
    send(16'h25A5, "R2");
    send(16'h0B3C, "R5");
    send(16'h6199, "R4");
    send(16'h6199, "R6");
    send(16'h0B11, "R7");
    send(16'h0BF2, "R7");
    send(16'hC4E1, "R7");
    send(16'h0B07, "R8");
    send(16'hAB56, "R8");
    send(16'h3A77, "R8");
    send(16'h0BFF, "R4");
    send(16'h7000, "R4");

    throttle = 1'b1;
    for (int i = 0; i < 120; i++) begin
      w = lfsr ^ (16'h9E37 * i[15:0]);
      if (i % 5 == 0) w = {1'b0, w[14:12], 4'hB, w[7:0]};
      send(w, "R9");
    end
    throttle = 1'b0;
    repeat (6) @(negedge clk);
    #2;
    check(sb.size() == 0 && taken == pushed, "R10", "items delivered", taken, pushed);
    finish_run();
  end
endmodule